// File: doc/BRIEF.md
# Cache Data ECC Scrub Controller

This controller handles a single-bit correctable ECC error found when data-cache data is read. Each error indication carries a source code, the index of the affected cache block, and, for loads, a flag that says whether the data array was read in the same cycle as the tag probe. A load error makes the controller request an instruction replay trap and hold the replayed stream at the map stage. If the bad data was read in the probe cycle, the load cannot have retired yet, so instruction retirement is also halted. If the data was read on a later load-queue retry, the load may already have retired, and retirement is left running. Errors from sub-quadword store merges and from victim reads cause neither a trap nor a stall.

For every accepted error the controller scrubs the whole block in two phases. In the first phase it reads each quadword of the block through the correction path into a local victim buffer. In the second phase it writes the corrected quadwords back into the cache. The map-stage stall and the retire stall are released only when the scrub of every load error that asked for them has finished. A sticky data-stream error flag is set when a scrub completes. Errors that arrive while a scrub is running wait in a small pending queue and are served one at a time, in arrival order.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, replay_trap, retire_stall, map_stall, dc_err_flag, rd_en and wr_en are all 0. A reset also clears a flag that was already set.
- R2: A load error (source code 0) with err_probe_cycle=1 raises retire_stall and map_stall in the cycle after err_valid. Both stay high until after the last writeback of that block, then fall on the same clock edge.
- R3: A load error with err_probe_cycle=0 raises map_stall in the cycle after err_valid, with the same release rule as R2. retire_stall stays low.
- R4: A load error gives a one-cycle replay_trap pulse in the cycle after err_valid. Store-merge errors (code 1) and victim-read errors (code 2) give no trap and no stall, whatever the value of err_probe_cycle.
- R5: Eviction reads the quadwords 0 to QW_PER_BLK-1 of the block in ascending order, one per cycle. Each read uses rd_addr = {block index, quadword}, and rd_data is taken one cycle after rd_en.
- R6: Writeback writes the same QW_PER_BLK addresses in ascending order. Each write carries the corrected data that was returned for that quadword.
- R7: No write of a block starts before all of its reads are done, and rd_en and wr_en are never high in the same cycle.
- R8: dc_err_flag is 0 until the first scrub completes. It goes high on the edge that releases the stalls and then stays high until reset.
- R9: Errors that arrive during a scrub are queued and scrubbed one at a time, in arrival order. The reads of one block start only after the last write of the previous block. At most PEND_DEPTH errors may wait at once.
- R10: An error with source code 3 is ignored: it starts no read or write, and it causes no trap and no stall.
- R11: Each load error holds its stalls until its own scrub is done. map_stall stays high while any queued or running load error is still unfinished. retire_stall can fall earlier, once the last probe-cycle load error has been scrubbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error indication strobe |
| err_src | input | 2 | Source: 0 load, 1 store merge, 2 victim read, 3 reserved |
| err_probe_cycle | input | 1 | Load data was read in the tag-probe cycle |
| err_idx | input | IDX_W | Index of the affected block |
| rd_en | output | 1 | Read through the correction path |
| rd_addr | output | IDX_W+log2(QW_PER_BLK) | Read address {index, quadword} |
| rd_data | input | DATA_W | Corrected quadword, valid one cycle after rd_en |
| wr_en | output | 1 | Cache write-back strobe |
| wr_addr | output | IDX_W+log2(QW_PER_BLK) | Write address {index, quadword} |
| wr_data | output | DATA_W | Corrected quadword written back |
| replay_trap | output | 1 | Replay trap request, one cycle per load error |
| retire_stall | output | 1 | Halt instruction retirement |
| map_stall | output | 1 | Hold the replayed stream at the map stage |
| dc_err_flag | output | 1 | Sticky flag, set when a scrub completes |

## Verification
The checker assumes the environment never presents an accepted error while the pending queue is full. The bench keeps to this by sending at most three errors in a burst, which leaves the four-entry queue short of full. The checker also assumes the correction path always answers exactly one cycle after rd_en. The bench models the cache as a function of the read address that is registered on the same edge as rd_en, so the write-back data can be predicted per address. Error strobes last a single cycle, and the source and flag inputs are returned to zero between them. This keeps the trap-origin property well-defined.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  typedef enum logic [1:0] {
    SRC_LOAD   = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_VICTIM = 2'd2,
    SRC_RSVD   = 2'd3
  } err_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_WBACK = 2'd2,
    ST_DONE  = 2'd3
  } scrub_state_e;

endpackage

// File: rtl/scrub_err_fifo.sv
module scrub_err_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [PTR_W:0]   cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (PTR_W+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/scrub_victim_buf.sv
module scrub_victim_buf #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int A_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [A_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [A_W-1:0]    rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/scrub_stall_track.sv
module scrub_stall_track #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_retire,
  input  logic inc_map,
  input  logic dec_retire,
  input  logic dec_map,
  input  logic trap_req,
  output logic retire_stall,
  output logic map_stall,
  output logic replay_trap
);

  logic [CNT_W-1:0] ret_cnt, map_cnt, ret_nx, map_nx;

  assign ret_nx = ret_cnt + CNT_W'(inc_retire) - CNT_W'(dec_retire);
  assign map_nx = map_cnt + CNT_W'(inc_map) - CNT_W'(dec_map);

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_cnt      <= '0;
      map_cnt      <= '0;
      retire_stall <= 1'b0;
      map_stall    <= 1'b0;
      replay_trap  <= 1'b0;
    end else begin
      ret_cnt      <= ret_nx;
      map_cnt      <= map_nx;
      retire_stall <= (ret_nx != '0);
      map_stall    <= (map_nx != '0);
      replay_trap  <= trap_req;
    end
  end

endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int QW_PER_BLK = 8,
  parameter int DATA_W     = 64,
  parameter int PEND_DEPTH = 4,
  localparam int QW_W   = $clog2(QW_PER_BLK),
  localparam int ADDR_W = IDX_W + QW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [1:0]        err_src,
  input  logic              err_probe_cycle,
  input  logic [IDX_W-1:0]  err_idx,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              replay_trap,
  output logic              retire_stall,
  output logic              map_stall,
  output logic              dc_err_flag
);

  localparam int REC_W = IDX_W + 2;
  localparam int CNT_W = $clog2(PEND_DEPTH + 2);
  localparam logic [QW_W:0] QW_N = (QW_W+1)'(QW_PER_BLK);

  // Accept side: classify the incoming error.
  err_src_e   src_e;
  logic       accept, is_load, needs_retire;
  logic [REC_W-1:0] rec_in, rec_out;
  logic       fifo_empty, fifo_full, pop;

  assign src_e        = err_src_e'(err_src);
  assign accept       = err_valid && (src_e != SRC_RSVD);
  assign is_load      = accept && (src_e == SRC_LOAD);
  assign needs_retire = is_load && err_probe_cycle;
  assign rec_in       = {needs_retire, is_load, err_idx};

  scrub_err_fifo #(.W(REC_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .push (accept),
    .din  (rec_in),
    .pop  (pop),
    .dout (rec_out),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  // Scrub sequencer.
  scrub_state_e     state;
  logic [IDX_W-1:0] job_idx;
  logic             job_retire, job_map;
  logic [QW_W:0]    rcnt, wcnt;
  logic             cap_v;
  logic [QW_W-1:0]  cap_qw;
  logic             vb_rd;
  logic             wr_en_q;
  logic [QW_W-1:0]  wr_qw_q;
  logic [DATA_W-1:0] vb_rdata;
  logic             done;

  assign pop   = (state == ST_IDLE) && !fifo_empty;
  assign rd_en = (state == ST_EVICT) && (rcnt != QW_N);
  assign vb_rd = (state == ST_WBACK) && (wcnt != QW_N);
  assign done  = (state == ST_DONE);

  assign rd_addr = {job_idx, rcnt[QW_W-1:0]};
  assign wr_en   = wr_en_q;
  assign wr_addr = {job_idx, wr_qw_q};
  assign wr_data = vb_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      job_idx     <= '0;
      job_retire  <= 1'b0;
      job_map     <= 1'b0;
      rcnt        <= '0;
      wcnt        <= '0;
      cap_v       <= 1'b0;
      cap_qw      <= '0;
      wr_en_q     <= 1'b0;
      wr_qw_q     <= '0;
      dc_err_flag <= 1'b0;
    end else begin
      cap_v   <= rd_en;
      cap_qw  <= rcnt[QW_W-1:0];
      wr_en_q <= vb_rd;
      wr_qw_q <= wcnt[QW_W-1:0];
      unique case (state)
        ST_IDLE: begin
          if (pop) begin
            {job_retire, job_map, job_idx} <= rec_out;
            rcnt  <= '0;
            wcnt  <= '0;
            state <= ST_EVICT;
          end
        end
        ST_EVICT: begin
          if (rd_en)       rcnt  <= rcnt + 1'b1;
          else if (!cap_v) state <= ST_WBACK;
        end
        ST_WBACK: begin
          if (vb_rd)          wcnt  <= wcnt + 1'b1;
          else if (!wr_en_q)  state <= ST_DONE;
        end
        ST_DONE: begin
          dc_err_flag <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  scrub_victim_buf #(.DATA_W(DATA_W), .DEPTH(QW_PER_BLK)) u_vbuf (
    .clk    (clk),
    .wr_en  (cap_v),
    .wr_addr(cap_qw),
    .wr_data(rd_data),
    .rd_en  (vb_rd),
    .rd_addr(wcnt[QW_W-1:0]),
    .rd_data(vb_rdata)
  );

  scrub_stall_track #(.CNT_W(CNT_W)) u_stall (
    .clk         (clk),
    .rst         (rst),
    .inc_retire  (needs_retire),
    .inc_map     (is_load),
    .dec_retire  (done && job_retire),
    .dec_map     (done && job_map),
    .trap_req    (is_load),
    .retire_stall(retire_stall),
    .map_stall   (map_stall),
    .replay_trap (replay_trap)
  );

endmodule

// File: rtl/ecc_scrub_ctrl_chk.sv
module ecc_scrub_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              err_valid,
  input logic [1:0]        err_src,
  input logic              pend_full,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              replay_trap,
  input logic              retire_stall,
  input logic              map_stall,
  input logic              dc_err_flag
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_src != 2'd3) |-> !pend_full); // R9

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R7

  AST_RETIRE_WITH_MAP: assert property (@(posedge clk) disable iff (rst)
    retire_stall |-> map_stall); // R2

  AST_TRAP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    replay_trap |-> ($past(err_valid) && $past(err_src) == 2'd0)); // R4

  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R5

  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(dc_err_flag) |-> dc_err_flag); // R8

  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(map_stall) |-> dc_err_flag); // R11

endmodule

bind ecc_scrub_ctrl ecc_scrub_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .err_valid   (err_valid),
  .err_src     (err_src),
  .pend_full   (fifo_full),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .replay_trap (replay_trap),
  .retire_stall(retire_stall),
  .map_stall   (map_stall),
  .dc_err_flag (dc_err_flag)
);

// File: tb/sim_ecc_scrub_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_scrub_ctrl;

  localparam int IDX_W = 6;
  localparam int QPB   = 8;
  localparam int DW    = 64;
  localparam int AW    = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic [1:0] err_src = 2'd0;
  logic err_probe = 1'b0;
  logic [IDX_W-1:0] err_idx = '0;
  logic rd_en, wr_en, replay_trap, retire_stall, map_stall, dc_err_flag;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ecc_scrub_ctrl u0 (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_src(err_src),
    .err_probe_cycle(err_probe), .err_idx(err_idx),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .replay_trap(replay_trap), .retire_stall(retire_stall),
    .map_stall(map_stall), .dc_err_flag(dc_err_flag)
  );

  function automatic logic [DW-1:0] gold(input logic [AW-1:0] a);
    return 64'h0123_4567_89AB_CDEF ^ ({55'd0, a} * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // Correction path model: corrected data one cycle after the read strobe.
  always @(posedge clk) if (rd_en === 1'b1) rd_data <= gold(rd_addr);

  logic [AW-1:0] rd_a [256];
  int            rd_c [256];
  int            rd_n = 0;
  logic [AW-1:0] wr_a [256];
  logic [DW-1:0] wr_d [256];
  int            wr_c [256];
  int            wr_n = 0;

  always @(negedge clk) begin
    if (rd_en === 1'b1 && rd_n < 256) begin
      rd_a[rd_n] <= rd_addr; rd_c[rd_n] <= cyc; rd_n <= rd_n + 1;
    end
    if (wr_en === 1'b1 && wr_n < 256) begin
      wr_a[wr_n] <= wr_addr; wr_d[wr_n] <= wr_data; wr_c[wr_n] <= cyc; wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_err(input logic [1:0] s, input logic p, input logic [IDX_W-1:0] i);
    err_valid = 1'b1; err_src = s; err_probe = p; err_idx = i;
    @(negedge clk);
    err_valid = 1'b0; err_src = 2'd0; err_probe = 1'b0;
  endtask

  task automatic wait_writes(input int target);
    for (int k = 0; k < 400 && wr_n < target; k++) @(negedge clk);
    chk(wr_n >= target, "R6 writeback finished", 64'(wr_n), 64'(target));
    repeat (6) @(negedge clk);
  endtask

  task automatic verify_block(input int rb, input int wb, input logic [IDX_W-1:0] idx);
    for (int q = 0; q < QPB; q++) begin
      chk(rd_a[rb+q] === {idx, 3'(q)}, "R5 read address", 64'(rd_a[rb+q]), 64'({idx, 3'(q)}));
      if (q > 0)
        chk(rd_c[rb+q] == rd_c[rb+q-1] + 1, "R5 consecutive reads", 64'(rd_c[rb+q]), 64'(rd_c[rb+q-1] + 1));
      chk(wr_a[wb+q] === {idx, 3'(q)}, "R6 write address", 64'(wr_a[wb+q]), 64'({idx, 3'(q)}));
      chk(wr_d[wb+q] === gold({idx, 3'(q)}), "R6 write data", wr_d[wb+q], gold({idx, 3'(q)}));
    end
    chk(wr_c[wb] > rd_c[rb+QPB-1], "R7 writes after reads", 64'(wr_c[wb]), 64'(rd_c[rb+QPB-1]));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(dc_err_flag === 1'b0 && map_stall === 1'b0 && retire_stall === 1'b0, "R1 outputs in reset",
        64'({dc_err_flag, map_stall, retire_stall}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(replay_trap === 1'b0, "R1 trap low", 64'(replay_trap), 64'd0);
    chk(retire_stall === 1'b0 && map_stall === 1'b0, "R1 stalls low", 64'({retire_stall, map_stall}), 64'd0);
    chk(dc_err_flag === 1'b0, "R1 flag low", 64'(dc_err_flag), 64'd0);
    chk(rd_en === 1'b0 && wr_en === 1'b0, "R1 no cache access", 64'({rd_en, wr_en}), 64'd0);
  endtask

  task automatic t_load_probe();
    int rb = rd_n;
    int wb = wr_n;
    bit held = 1'b1;
    int drop;
    send_err(2'd0, 1'b1, 6'd5);
    chk(replay_trap === 1'b1, "R4 trap raised", 64'(replay_trap), 64'd1);
    chk(retire_stall === 1'b1, "R2 retire stall raised", 64'(retire_stall), 64'd1);
    chk(map_stall === 1'b1, "R2 map stall raised", 64'(map_stall), 64'd1);
    chk(dc_err_flag === 1'b0, "R8 flag before done", 64'(dc_err_flag), 64'd0);
    @(negedge clk);
    chk(replay_trap === 1'b0, "R4 trap one cycle", 64'(replay_trap), 64'd0);
    for (int k = 0; k < 300 && map_stall === 1'b1; k++) begin
      if (retire_stall !== 1'b1) held = 1'b0;
      @(negedge clk);
    end
    drop = cyc;
    chk(held, "R2 retire held with map", 64'(held), 64'd1);
    chk(map_stall === 1'b0 && retire_stall === 1'b0, "R2 stalls released together",
        64'({map_stall, retire_stall}), 64'd0);
    chk(dc_err_flag === 1'b1, "R8 flag set", 64'(dc_err_flag), 64'd1);
    chk(wr_n - wb == QPB, "R6 write count", 64'(wr_n - wb), 64'(QPB));
    chk(rd_n - rb == QPB, "R5 read count", 64'(rd_n - rb), 64'(QPB));
    verify_block(rb, wb, 6'd5);
    chk(drop > wr_c[wb+QPB-1], "R2 release after writeback", 64'(drop), 64'(wr_c[wb+QPB-1]));
  endtask

  task automatic t_load_retry();
    int rb = rd_n;
    int wb = wr_n;
    bit saw_ret = 1'b0;
    send_err(2'd0, 1'b0, 6'd7);
    chk(replay_trap === 1'b1, "R4 trap on retry load", 64'(replay_trap), 64'd1);
    chk(map_stall === 1'b1, "R3 map stall raised", 64'(map_stall), 64'd1);
    for (int k = 0; k < 300 && map_stall === 1'b1; k++) begin
      if (retire_stall !== 1'b0) saw_ret = 1'b1;
      @(negedge clk);
    end
    chk(!saw_ret, "R3 no retire stall", 64'(saw_ret), 64'd0);
    chk(map_stall === 1'b0, "R3 map stall released", 64'(map_stall), 64'd0);
    chk(wr_n - wb == QPB, "R6 write count", 64'(wr_n - wb), 64'(QPB));
    verify_block(rb, wb, 6'd7);
  endtask

  task automatic t_nonload(input logic [1:0] s, input logic p, input logic [IDX_W-1:0] idx);
    int rb = rd_n;
    int wb = wr_n;
    send_err(s, p, idx);
    chk(replay_trap === 1'b0, "R4 no trap for non-load", 64'(replay_trap), 64'd0);
    chk(retire_stall === 1'b0 && map_stall === 1'b0, "R4 no stall for non-load",
        64'({retire_stall, map_stall}), 64'd0);
    wait_writes(wb + QPB);
    chk(rd_n - rb == QPB, "R5 read count", 64'(rd_n - rb), 64'(QPB));
    verify_block(rb, wb, idx);
    chk(dc_err_flag === 1'b1, "R8 flag stays set", 64'(dc_err_flag), 64'd1);
  endtask

  task automatic t_reserved();
    int rb = rd_n;
    int wb = wr_n;
    send_err(2'd3, 1'b1, 6'd40);
    chk(replay_trap === 1'b0 && map_stall === 1'b0 && retire_stall === 1'b0, "R10 no trap or stall",
        64'({replay_trap, map_stall, retire_stall}), 64'd0);
    repeat (30) @(negedge clk);
    chk(rd_n == rb, "R10 no reads", 64'(rd_n - rb), 64'd0);
    chk(wr_n == wb, "R10 no writes", 64'(wr_n - wb), 64'd0);
  endtask

  task automatic t_queue();
    int rb = rd_n;
    int wb = wr_n;
    int rdrop = 0;
    int mdrop;
    send_err(2'd0, 1'b1, 6'd2);
    @(negedge clk);
    @(negedge clk);
    send_err(2'd2, 1'b0, 6'd9);
    send_err(2'd0, 1'b0, 6'd12);
    for (int k = 0; k < 600 && map_stall === 1'b1; k++) begin
      if (rdrop == 0 && retire_stall === 1'b0) rdrop = cyc;
      @(negedge clk);
    end
    mdrop = cyc;
    repeat (2) @(negedge clk);
    chk(wr_n - wb == 3 * QPB, "R9 all blocks written", 64'(wr_n - wb), 64'(3 * QPB));
    verify_block(rb, wb, 6'd2);
    verify_block(rb + QPB, wb + QPB, 6'd9);
    verify_block(rb + 2 * QPB, wb + 2 * QPB, 6'd12);
    chk(wr_a[wb+QPB][AW-1:3] === 6'd9, "R9 second block in order", 64'(wr_a[wb+QPB][AW-1:3]), 64'd9);
    chk(wr_a[wb+2*QPB][AW-1:3] === 6'd12, "R9 third block in order", 64'(wr_a[wb+2*QPB][AW-1:3]), 64'd12);
    chk(rd_c[rb+QPB] > wr_c[wb+QPB-1], "R9 one scrub at a time", 64'(rd_c[rb+QPB]), 64'(wr_c[wb+QPB-1]));
    chk(rdrop > 0 && rdrop < mdrop, "R11 retire released before map", 64'(rdrop), 64'(mdrop));
    chk(rdrop > wr_c[wb+QPB-1], "R11 retire held for first load", 64'(rdrop), 64'(wr_c[wb+QPB-1]));
    chk(mdrop > wr_c[wb+3*QPB-1], "R11 map held until last load", 64'(mdrop), 64'(wr_c[wb+3*QPB-1]));
  endtask

  task automatic t_reset_again();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dc_err_flag === 1'b0, "R1 reset clears flag", 64'(dc_err_flag), 64'd0);
  endtask

  initial begin
    t_reset();
    t_load_probe();
    t_load_retry();
    t_nonload(2'd1, 1'b1, 6'd20);
    t_nonload(2'd2, 1'b0, 6'd33);
    t_reserved();
    t_queue();
    t_reset_again();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule